// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block holds the digital half of an integrating dual-slope converter. An external integrator, zero-crossing comparator and analog input switch are driven by it. When a start request is seen while the block is idle, it first holds the integrator's discharge output active for a fixed number of clocks. It then routes the unknown input to the integrator for exactly one full range of its counter. After that it restarts the same counter from zero and switches the integrator to the negative reference. It counts until the comparator reports that the integrator has fallen below zero.

The count reached at that moment is proportional to the input voltage and becomes the result. Because both slopes are timed by one clock, the result is a ratio of two intervals and does not depend on the clock frequency. A one-clock done pulse marks each new result. If the integrator has not crossed zero after a full counter range of run-down, the conversion ends with an all-ones result and an overrange flag.

The sequencer has four states. `ST_IDLE` waits for start. `ST_DISCHARGE` holds the integrator reset. `ST_RUNUP` integrates the input. `ST_RUNDOWN` de-integrates on the reference. The transitions are:
- IDLE→DISCHARGE on start.
- DISCHARGE→RUNUP after `DIS_CYC` clocks.
- RUNUP→RUNDOWN after 2^`CNT_W` clocks.
- RUNDOWN→IDLE on a comparator low sample, or when the counter reaches all ones.

Top module: `dslope_seq`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first start, `int_rst_o`, `sel_ref_o`, `done_o` and `ovr_o` are 0 and `result_o` is 0.
- R2: A `start_i` high sampled in the idle state makes `int_rst_o` high from the next cycle for exactly `DIS_CYC` consecutive cycles.
- R3: Directly after the discharge cycles, run-up lasts exactly 2^`CNT_W` cycles, with `int_rst_o` = 0 and `sel_ref_o` = 0 (0 selects the input voltage).
- R4: Directly after run-up, `sel_ref_o` = 1 (1 selects the negative reference) and the count restarts from 0 in the first run-down cycle.
- R5: `cmp_i` = 1 means the integrator is above zero. The result equals the number of run-down cycles sampled with `cmp_i` = 1 before the first cycle sampled with `cmp_i` = 0. In the cycle after that sample, `done_o` is high for exactly one cycle, `sel_ref_o` has returned to 0 and `result_o` holds the count.
- R6: If `cmp_i` is 1 in all 2^`CNT_W` run-down cycles, the conversion ends after the last one with `result_o` all ones and `ovr_o` = 1. Any conversion ended by the comparator sets `ovr_o` = 0.
- R7: A `start_i` high sampled during discharge, run-up or run-down has no effect on the phase sequence, and no new conversion follows the current one.
- R8: `result_o` and `ovr_o` change only in a cycle where `done_o` is high.
- R9: `int_rst_o` and `sel_ref_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Conversion clock, times both slopes |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, honoured only when idle |
| cmp_i | input | 1 | Comparator output, 1 while the integrator is above zero |
| sel_ref_o | output | 1 | Input switch select: 0 = input voltage, 1 = negative reference |
| int_rst_o | output | 1 | Integrator discharge control, active high |
| result_o | output | CNT_W | Run-down count of the last conversion |
| done_o | output | 1 | One-cycle pulse when a new result is valid |
| ovr_o | output | 1 | Last conversion ran out of run-down range |

## Verification
The bench aims at the ends of the run-down window:
- A comparator already low in the first run-down cycle must give 0. A design that counts before it tests the comparator would report 1.
- A comparator trip in the very last cycle must give all ones with no overrange flag.
- A comparator that never trips must give all ones with the flag set. A design that mixes up these two cases flags a valid reading, or misses a saturated one.

Start requests are issued during run-up and during run-down. A design that honours them would restart the discharge or lengthen run-up, and the per-cycle model comparison would show this at once. Back-to-back conversions check that the counter really restarts from zero between the phases. A design that carried the run-up count over would give results offset by a full range.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_DISCHARGE = 2'd1,
        ST_RUNUP     = 2'd2,
        ST_RUNDOWN   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dslope_ctr.sv
// Shared phase counter: synchronous clear has priority over increment,
// and the counter wraps to zero after its all-ones value.
module dslope_ctr #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         full_o
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    assign full_o = (cnt_o == ALL_ONES);
endmodule

// File: rtl/dslope_fsm.sv
// Phase sequencer: a state register, next-state logic, and Moore/Mealy outputs.
module dslope_fsm
    import dslope_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DIS_CYC = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             cmp_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             full_i,
    output logic             clr_o,
    output logic             inc_o,
    output logic             finish_o,
    output logic             ovr_hit_o,
    output logic             int_rst_o,
    output logic             sel_ref_o
);
    localparam logic [CNT_W-1:0] DIS_LAST = CNT_W'(DIS_CYC - 1);

    seq_state_e state_q, state_d;
    logic       dis_end;
    logic       rd_end;

    assign dis_end = (cnt_i == DIS_LAST);
    assign rd_end  = !cmp_i || full_i;

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_DISCHARGE;
            ST_DISCHARGE: if (dis_end) state_d = ST_RUNUP;
            ST_RUNUP:     if (full_i)  state_d = ST_RUNDOWN;
            ST_RUNDOWN:   if (rd_end)  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        clr_o     = 1'b0;
        inc_o     = 1'b0;
        finish_o  = 1'b0;
        ovr_hit_o = 1'b0;
        int_rst_o = 1'b0;
        sel_ref_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clr_o = 1'b1;
            end
            ST_DISCHARGE: begin
                int_rst_o = 1'b1;
                clr_o     = dis_end;
                inc_o     = !dis_end;
            end
            ST_RUNUP: begin
                inc_o = 1'b1;  // wraps from all ones back to zero
            end
            ST_RUNDOWN: begin
                sel_ref_o = 1'b1;
                if (rd_end) begin
                    finish_o  = 1'b1;
                    ovr_hit_o = cmp_i;
                    clr_o     = 1'b1;
                end else begin
                    inc_o = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/dslope_res.sv
// Result holding register and done pulse.
module dslope_res #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ovr_i,
    output logic [CNT_W-1:0] result_o,
    output logic             ovr_o,
    output logic             done_o
);
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            result_o <= '0;
            ovr_o    <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= load_i;
            if (load_i) begin
                result_o <= cnt_i;  // all ones on the overrange exit
                ovr_o    <= ovr_i;
            end
        end
    end
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq #(
    parameter int CNT_W   = 8,
    parameter int DIS_CYC = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic             sel_ref_o,
    output logic             int_rst_o,
    output logic [CNT_W-1:0] result_o,
    output logic             done_o,
    output logic             ovr_o
);
    localparam longint RANGE = longint'(1) << CNT_W;

    initial begin
        if (DIS_CYC < 1 || longint'(DIS_CYC) > RANGE) begin
            $error("dslope_seq: DIS_CYC must lie in 1..2**CNT_W");
        end
    end

    logic [CNT_W-1:0] cnt;
    logic             full;
    logic             clr;
    logic             inc;
    logic             finish;
    logic             ovr_hit;

    dslope_ctr #(.W(CNT_W)) ctr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr),
        .inc_i  (inc),
        .cnt_o  (cnt),
        .full_o (full)
    );

    dslope_fsm #(.CNT_W(CNT_W), .DIS_CYC(DIS_CYC)) fsm_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .cmp_i     (cmp_i),
        .cnt_i     (cnt),
        .full_i    (full),
        .clr_o     (clr),
        .inc_o     (inc),
        .finish_o  (finish),
        .ovr_hit_o (ovr_hit),
        .int_rst_o (int_rst_o),
        .sel_ref_o (sel_ref_o)
    );

    dslope_res #(.CNT_W(CNT_W)) res_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (finish),
        .cnt_i    (cnt),
        .ovr_i    (ovr_hit),
        .result_o (result_o),
        .ovr_o    (ovr_o),
        .done_o   (done_o)
    );
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             cmp_i,
    input logic             sel_ref_o,
    input logic             int_rst_o,
    input logic [CNT_W-1:0] result_o,
    input logic             done_o,
    input logic             ovr_o
);
    assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_after_rundown_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(sel_ref_o) && !sel_ref_o));

    assert_ovr_all_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_o |-> (result_o == {CNT_W{1'b1}}));

    assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(result_o) && $stable(ovr_o)));

    assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(int_rst_o && sel_ref_o));

    assert_discharge_on_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(int_rst_o) |-> $past(start_i));

    assert_rundown_after_runup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sel_ref_o) |-> !$past(int_rst_o));
endmodule

bind dslope_seq dslope_seq_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cmp_i     (cmp_i),
    .sel_ref_o (sel_ref_o),
    .int_rst_o (int_rst_o),
    .result_o  (result_o),
    .done_o    (done_o),
    .ovr_o     (ovr_o)
);

// File: tb/dslope_seq_tb_top.sv
module dslope_seq_tb_top;
    localparam int CNT_W   = 6;
    localparam int DIS_CYC = 3;
    localparam int MAXV    = (1 << CNT_W) - 1;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             start_i = 1'b0;
    logic             cmp_i = 1'b1;
    logic             sel_ref_o;
    logic             int_rst_o;
    logic [CNT_W-1:0] result_o;
    logic             done_o;
    logic             ovr_o;

    int tests = 0;
    int fails = 0;
    int trip = 0;
    int rd_k = 0;
    bit reported = 0;

    // Reference model state
    int m_phase = 0;  // 0 idle, 1 discharge, 2 run-up, 3 run-down
    int m_k = 0;
    int m_res = 0;
    bit m_ovr = 0;
    bit m_done = 0;

    always #5 clk_i = ~clk_i;

    dslope_seq #(.CNT_W(CNT_W), .DIS_CYC(DIS_CYC)) dut_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .cmp_i     (cmp_i),
        .sel_ref_o (sel_ref_o),
        .int_rst_o (int_rst_o),
        .result_o  (result_o),
        .done_o    (done_o),
        .ovr_o     (ovr_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
        end
    endtask

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            m_phase = 0; m_k = 0; m_res = 0; m_ovr = 0; m_done = 0;
        end else begin
            m_done = 0;
            case (m_phase)
                0: if (start_i) begin m_phase = 1; m_k = 0; end
                1: if (m_k == DIS_CYC - 1) begin m_phase = 2; m_k = 0; end else m_k++;
                2: if (m_k == MAXV) begin m_phase = 3; m_k = 0; end else m_k++;
                default: begin
                    if (!cmp_i) begin
                        m_res = m_k; m_ovr = 0; m_done = 1; m_phase = 0; m_k = 0;
                    end else if (m_k == MAXV) begin
                        m_res = MAXV; m_ovr = 1; m_done = 1; m_phase = 0; m_k = 0;
                    end else m_k++;
                end
            endcase
        end
    end

    // Per-cycle comparison and comparator stimulus, away from the active edge
    always @(negedge clk_i) begin
        if (rst_ni) begin
            check(int_rst_o == (m_phase == 1), "R2 int_rst_o", int'(int_rst_o), int'(m_phase == 1));
            check(sel_ref_o == (m_phase == 3), "R4 sel_ref_o", int'(sel_ref_o), int'(m_phase == 3));
            check(done_o == m_done, "R5 done_o", int'(done_o), int'(m_done));
            check(int'(result_o) == m_res, "R8 result_o", int'(result_o), m_res);
            check(ovr_o == m_ovr, "R6 ovr_o", int'(ovr_o), int'(m_ovr));
            check(!(int_rst_o && sel_ref_o), "R9 overlap", int'(int_rst_o && sel_ref_o), 0);
        end
        if (sel_ref_o) begin
            cmp_i = (rd_k < trip);
            rd_k++;
        end else begin
            cmp_i = 1'b1;
            rd_k = 0;
        end
    end

    task automatic conv(input int t, input int mid_at);
        int exp_r;
        bit exp_o;
        bit seen;
        exp_o = (t > MAXV);
        exp_r = exp_o ? MAXV : t;
        trip = t;
        @(negedge clk_i); start_i = 1'b1;
        @(negedge clk_i); start_i = 1'b0;
        seen = 0;
        for (int i = 1; i < 400; i++) begin
            @(negedge clk_i);
            start_i = (i == mid_at);  // R7: stray start during the conversion
            if (done_o) begin seen = 1; break; end
        end
        start_i = 1'b0;
        check(seen, "R5 done seen", int'(seen), 1);
        check(int'(result_o) == exp_r, "R5 result", int'(result_o), exp_r);
        check(ovr_o == exp_o, "R6 overrange", int'(ovr_o), int'(exp_o));
        repeat (2) @(negedge clk_i);
        check(!int_rst_o && !sel_ref_o, "R7 no restart", int'(int_rst_o | sel_ref_o), 0);
        check(int'(result_o) == exp_r, "R8 result held", int'(result_o), exp_r);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        check(!int_rst_o && !sel_ref_o && !done_o && !ovr_o && result_o == 0,
              "R1 reset outputs", int'({int_rst_o, sel_ref_o, done_o, ovr_o}), 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        check(!int_rst_o && !sel_ref_o && result_o == 0, "R1 idle after reset",
              int'(result_o), 0);
        conv(0, 0);           // immediate trip: zero result
        conv(1, 0);
        conv(17, 10);         // stray start in run-up (R3 window)
        conv(40, DIS_CYC + MAXV + 5);  // stray start in run-down (R4 window)
        conv(MAXV - 1, 1);    // stray start in discharge
        conv(MAXV, 0);        // trip in last run-down cycle, no overrange
        conv(MAXV + 1, 0);    // never trips: overrange
        conv(5, 0);           // flag clears after an overrange
        conv(500, 0);
        conv(33, 0);
        summary();
        $finish;
    end

    initial begin
        #2000000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule